// File: doc/BRIEF.md
# Lookup-Table Arithmetic Logic Unit

This block is a small ALU that contains no run-time adder, comparator or logic array in its result path. Each answer, the result word together with its three status flags, is stored in a read-only table. A constant function fills that table when the design is elaborated. The operation code and the two operands together form the table address. The read is registered, so an answer appears one clock after its request.

The table is split into one segment per operation. AND, OR, add and NOR give the same answer when their operands are swapped. For these four operations the block first orders the operands so that the smaller value comes first. Each of their segments then holds only the N·(N+1)/2 unordered pairs, where N = 2^W. Subtract and set-less-than use the operands exactly as given, so their segments hold all N·N ordered pairs. A single extra entry serves every undefined operation code. With the default width of 4 bits the table has 1057 entries.

Top module: `lut_alu`

## Requirements
- R1: The operation codes are 4'b0000 AND, 4'b0001 OR and 4'b1100 NOR. For these three codes the result is the bitwise function of a and b.
- R2: Code 4'b0010 (add) gives (a+b) mod 2^W. The carry output is the bit carried out of position W-1. The overflow output is set when two operands of equal sign produce a result of the other sign.
- R3: Code 4'b0110 (subtract) gives (a−b) mod 2^W. The carry output is 1 when no borrow occurs (a ≥ b, unsigned). The overflow output is set when the signed difference falls outside the signed W-bit range.
- R4: Code 4'b0111 (set-less-than) compares a and b as two's-complement values. It returns 1 in bit 0 when a < b and 0 otherwise. All upper result bits are 0.
- R5: For the six defined codes, the zero output is 1 exactly when the result is all zeros.
- R6: For AND, OR, NOR and set-less-than, the carry and overflow outputs are 0.
- R7: Any other operation code returns a zero result with the zero, carry and overflow outputs all 0.
- R8: For AND, OR, add and NOR, the output is the same whichever order the operands arrive in. The operands are placed smaller first before the table is addressed. Subtract and set-less-than are never reordered.
- R9: A request with in_valid high produces out_valid high and its answer on the next rising clock edge. out_valid is low after a clock with in_valid low. Reset (rst_n low) clears out_valid, result and all flags.
- R10: While in_valid is low, result and flags keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Answer strobe, one clock after the request |
| result | output | W | Result word |
| zero | output | 1 | Result is all zeros |
| carry | output | 1 | Carry-out from add, no-borrow from subtract |
| overflow | output | 1 | Signed overflow from add or subtract |

## Verification
The hardest thing to show from the ports is the operand folding. Every folded table slot must be reachable from both operand orders, and the triangular offset for each larger operand must land on the right entry, including the diagonal where a equals b. The stimulus therefore sweeps every ordered pair for all six operations, which reaches each commutative entry twice and each diagonal entry once. Idle cycles with changing inputs are interleaved with the sweep, and a reset is applied in mid-stream, to exercise result holding and clearing.

// File: rtl/lut_alu_pkg.sv
package lut_alu_pkg;

  localparam int OP_W      = 4;
  localparam int NUM_FLAGS = 3;
  localparam int NUM_COMM  = 4;
  localparam int NUM_ORD   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_UNDEF = 4'b1111;

  function automatic logic op_is_comm(logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) || (op == OP_NOR);
  endfunction

  function automatic logic op_is_ord(logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // segment number within the folded (commutative) region
  function automatic int comm_seg(logic [OP_W-1:0] op);
    case (op)
      OP_AND:  return 0;
      OP_OR:   return 1;
      OP_ADD:  return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [OP_W-1:0] comm_op_at(int seg);
    case (seg)
      0:       return OP_AND;
      1:       return OP_OR;
      2:       return OP_ADD;
      default: return OP_NOR;
    endcase
  endfunction

  // segment number within the ordered region
  function automatic int ord_seg(logic [OP_W-1:0] op);
    return (op == OP_SUB) ? 0 : 1;
  endfunction

  function automatic logic [OP_W-1:0] ord_op_at(int seg);
    return (seg == 0) ? OP_SUB : OP_SLT;
  endfunction

endpackage

// File: rtl/lut_alu_canon.sv
// Puts commutative operands into canonical order (smaller value first).
module lut_alu_canon
  import lut_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    lo_o,
  output logic [W-1:0]    hi_o,
  output logic            swap_o
);

  always_comb begin
    swap_o = op_is_comm(op_i) && (a_i > b_i);
    lo_o   = swap_o ? b_i : a_i;
    hi_o   = swap_o ? a_i : b_i;
  end

endmodule

// File: rtl/lut_alu_index.sv
// Forms the table address from the operation and the canonical operands.
module lut_alu_index
  import lut_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0]                op_i,
  input  logic [W-1:0]                   lo_i,
  input  logic [W-1:0]                   hi_i,
  output logic [$clog2(NUM_COMM*((1<<W)*((1<<W)+1)/2)
                       + NUM_ORD*(1<<W)*(1<<W) + 1)-1:0] addr_o
);

  localparam int N     = 1 << W;
  localparam int TRI   = N * (N + 1) / 2;
  localparam int SQ    = N * N;
  localparam int TOTAL = NUM_COMM * TRI + NUM_ORD * SQ + 1;
  localparam int AW    = $clog2(TOTAL);

  // Folded segments: row hi starts at hi*(hi+1)/2, column lo <= hi.
  // Ordered segments: full square, row = first operand.
  // The final entry serves every undefined code.
  function automatic logic [AW-1:0] form_addr(logic [OP_W-1:0] op,
                                              logic [W-1:0] lo,
                                              logic [W-1:0] hi);
    int idx;
    if (op_is_comm(op))
      idx = comm_seg(op) * TRI + (int'(hi) * (int'(hi) + 1)) / 2 + int'(lo);
    else if (op_is_ord(op))
      idx = NUM_COMM * TRI + ord_seg(op) * SQ + int'(lo) * N + int'(hi);
    else
      idx = TOTAL - 1;
    return AW'(idx);
  endfunction

  assign addr_o = form_addr(op_i, lo_i, hi_i);

endmodule

// File: rtl/lut_alu_table.sv
// Elaboration-time table of answers with a registered read port.
module lut_alu_table
  import lut_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [$clog2(NUM_COMM*((1<<W)*((1<<W)+1)/2)
                       + NUM_ORD*(1<<W)*(1<<W) + 1)-1:0] rd_addr,
  output logic [W+NUM_FLAGS-1:0]    rd_data,
  output logic                      rd_valid
);

  localparam int N     = 1 << W;
  localparam int TRI   = N * (N + 1) / 2;
  localparam int SQ    = N * N;
  localparam int TOTAL = NUM_COMM * TRI + NUM_ORD * SQ + 1;
  localparam int EW    = W + NUM_FLAGS;

  // Entry layout: {result, zero, carry, overflow}
  function automatic logic [EW-1:0] eval_op(logic [OP_W-1:0] op,
                                            logic [W-1:0] a,
                                            logic [W-1:0] b);
    logic [W:0]   ext;
    logic [W-1:0] r;
    logic         c, v, known;
    ext   = '0;
    c     = 1'b0;
    v     = 1'b0;
    known = 1'b1;
    case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_NOR: r = ~(a | b);
      OP_ADD: begin
        ext = {1'b0, a} + {1'b0, b};
        r   = ext[W-1:0];
        c   = ext[W];
        v   = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      OP_SUB: begin
        ext = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        r   = ext[W-1:0];
        c   = ext[W];
        v   = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      OP_SLT: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: begin
        r     = '0;
        known = 1'b0;
      end
    endcase
    return {r, known && (r == '0), c, v};
  endfunction

  // Decode a table position back into its operation and operands.
  function automatic logic [EW-1:0] build_entry(int i);
    int            k, seg, row;
    logic [OP_W-1:0] op;
    logic [W-1:0]  x, y;
    if (i < NUM_COMM * TRI) begin
      seg = i / TRI;
      k   = i % TRI;
      row = 0;
      for (int h = 0; h < N; h++)
        if ((h * (h + 1)) / 2 <= k) row = h;
      op = comm_op_at(seg);
      x  = W'(k - (row * (row + 1)) / 2);
      y  = W'(row);
    end else if (i < NUM_COMM * TRI + NUM_ORD * SQ) begin
      k   = i - NUM_COMM * TRI;
      seg = k / SQ;
      k   = k % SQ;
      op  = ord_op_at(seg);
      x   = W'(k / N);
      y   = W'(k % N);
    end else begin
      op = OP_UNDEF;
      x  = '0;
      y  = '0;
    end
    return eval_op(op, x, y);
  endfunction

  logic [EW-1:0] rom [TOTAL];

  for (genvar gi = 0; gi < TOTAL; gi++) begin : g_entry
    localparam logic [EW-1:0] ENTRY = build_entry(gi);
    assign rom[gi] = ENTRY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rom[rd_addr];
    end
  end

endmodule

// File: rtl/lut_alu.sv
module lut_alu
  import lut_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            zero,
  output logic            carry,
  output logic            overflow
);

  localparam int N     = 1 << W;
  localparam int TRI   = N * (N + 1) / 2;
  localparam int SQ    = N * N;
  localparam int TOTAL = NUM_COMM * TRI + NUM_ORD * SQ + 1;
  localparam int AW    = $clog2(TOTAL);
  localparam int EW    = W + NUM_FLAGS;

  logic [W-1:0]  canon_lo, canon_hi;
  logic          canon_swap;
  logic [AW-1:0] tbl_addr;
  logic [EW-1:0] tbl_data;

  lut_alu_canon #(.W(W)) u_canon (
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .lo_o   (canon_lo),
    .hi_o   (canon_hi),
    .swap_o (canon_swap)
  );

  lut_alu_index #(.W(W)) u_index (
    .op_i   (op),
    .lo_i   (canon_lo),
    .hi_i   (canon_hi),
    .addr_o (tbl_addr)
  );

  lut_alu_table #(.W(W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (in_valid),
    .rd_addr  (tbl_addr),
    .rd_data  (tbl_data),
    .rd_valid (out_valid)
  );

  assign {result, zero, carry, overflow} = tbl_data;

  // R8
  canon_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_comm(op)) |-> (canon_lo <= canon_hi));

  // R8
  canon_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_is_comm(op)) |-> (!canon_swap && canon_lo == a && canon_hi == b));

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(tbl_addr) < TOTAL));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({result, zero, carry, overflow}));

  // R7
  undef_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_is_comm(op) && !op_is_ord(op)) |=>
      (result == '0 && !zero && !carry && !overflow));

  // R6
  no_arith_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_NOR || op == OP_SLT)) |=>
      (!carry && !overflow));

  // R4
  slt_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SLT) |=> (result[W-1:1] == '0));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_is_comm(op) || op_is_ord(op))) |=> (zero == (result == '0)));

endmodule

// File: tb/lut_alu_test.sv
module lut_alu_test;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         zero, carry, overflow;

  int errors = 0;
  int checks = 0;

  bit    exp_pend = 0;
  int    exp_r = 0;
  bit    exp_z = 0, exp_c = 0, exp_v = 0;
  string exp_tag = "R9";

  always #5 clk = ~clk;

  lut_alu #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .zero(zero), .carry(carry),
    .overflow(overflow)
  );

  function automatic int to_signed(int x);
    return (x >= N / 2) ? x - N : x;
  endfunction

  // Behavioural reference written from the requirements.
  task automatic ref_calc(input int o, input int x, input int y,
                          output int r, output bit z, output bit c, output bit v,
                          output string tag);
    int s;
    bit known;
    c = 0; v = 0; known = 1;
    case (o)
      0:  begin r = x & y;               tag = "R1 R5 R6"; end
      1:  begin r = x | y;               tag = "R1 R5 R6"; end
      12: begin r = (~(x | y)) & (N-1);  tag = "R1 R5 R6"; end
      2: begin
        r = (x + y) % N; c = (x + y) >= N;
        s = to_signed(x) + to_signed(y);
        v = (s > N/2 - 1) || (s < -N/2);
        tag = "R2 R5";
      end
      6: begin
        r = (x - y + N) % N; c = (x >= y);
        s = to_signed(x) - to_signed(y);
        v = (s > N/2 - 1) || (s < -N/2);
        tag = "R3 R5";
      end
      7: begin r = (to_signed(x) < to_signed(y)) ? 1 : 0; tag = "R4 R5 R6"; end
      default: begin r = 0; known = 0; tag = "R7"; end
    endcase
    z = known && (r == 0);
    if ((o == 0 || o == 1 || o == 2 || o == 12) && x > y) tag = {tag, " R8"};
  endtask

  task automatic check_outputs();
    checks++;
    if (out_valid !== exp_pend) begin
      errors++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, exp_pend);
    end
    checks++;
    if (result !== W'(exp_r) || zero !== exp_z || carry !== exp_c || overflow !== exp_v) begin
      errors++;
      $display("FAIL %s result/z/c/v actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b",
               exp_pend ? exp_tag : "R10", result, zero, carry, overflow,
               exp_r, exp_z, exp_c, exp_v);
    end
  endtask

  // One clock: check the answer due now, then drive the next request.
  task automatic step(input bit v, input int o, input int x, input int y);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    op = 4'(o);
    a  = W'(x);
    b  = W'(y);
    exp_pend = v;
    if (v) ref_calc(o, x, y, exp_r, exp_z, exp_c, exp_v, exp_tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int codes[6] = '{0, 1, 2, 6, 7, 12};
    repeat (3) @(negedge clk);
    // R9 reset state
    exp_pend = 0; exp_r = 0; exp_z = 0; exp_c = 0; exp_v = 0;
    check_outputs();
    rst_n = 1'b1;

    // exhaustive sweep of defined codes, with idle cycles mixed in (R10)
    foreach (codes[k]) begin
      for (int x = 0; x < N; x++) begin
        for (int y = 0; y < N; y++) begin
          step(1, codes[k], x, y);
          if (((x * N + y) % 7) == 3) step(0, (x + y) % 16, y, x);
        end
      end
    end

    // R7 undefined codes
    for (int o = 0; o < 16; o++) begin
      if (o != 0 && o != 1 && o != 2 && o != 6 && o != 7 && o != 12) begin
        for (int x = 0; x < N; x += 5) step(1, o, x, N - 1 - x);
      end
    end

    // R9 mid-stream reset clears a pending answer
    step(1, 2, 9, 9);
    step(0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    op = 4'd2; a = W'(3); b = W'(4);
    @(negedge clk);
    exp_pend = 0; exp_r = 0; exp_z = 0; exp_c = 0; exp_v = 0;
    check_outputs();
    in_valid = 1'b0;
    rst_n = 1'b1;
    step(1, 6, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule